// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a system-management watchdog behind a small byte-addressed register bank. Software programs a timer value and starts the watchdog by writing the first control register or the reload register. From then on the timer counts down by one step for each pulse on the prescaler tick input. If software does not reload it in time, the first expiry sets a timeout flag, raises a one-cycle SMI or NMI pulse and starts the count again from the timer value. A second expiry with no reload in between sets the second-timeout and boot flags and requests a reboot. The reboot is suppressed when the no-reboot strap is high or when the no-reboot configuration bit is set. While the reboot is suppressed, the second expiry acts as an interrupt, like the first.

Two mailbox bytes let software signal the management handler. A data-in write raises an SMI, and a data-out write sets an interrupt status flag. A lock bit in the first control register can be set by software, and only a reset clears it.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the registers read as follows: the timer value is 4, control 2 is 0x0008 and the software IRQ byte is 0x03. Every other register reads 0, and the timer is stopped.
- R2: The register map uses 16-bit words at these byte offsets:
  - 0x00: count/reload
  - 0x02: mailbox, with data-in as the low byte and data-out as the high byte
  - 0x04: status 1
  - 0x06: status 2
  - 0x08: control 1
  - 0x0A: control 2
  - 0x0C: timer value (10 bits)
  - 0x0E: software IRQ byte (low byte)

  The map is little-endian. be_i[0] selects the low byte and be_i[1] the high byte. An access at an odd address is a byte access to the high byte of that word: it uses be_i[0] and wdata_i[7:0], and the byte is returned on rdata_o[7:0]. Offsets from 0x10 up read 0.
- R3: The timer starts only when the halt bit (control 1 bit 0) is clear and the timer value is greater than 1. A write to control 1 starts the timer from the timer value when both conditions hold, and stops it otherwise.
- R4: While the timer runs, the count/reload register reads the remaining ticks. Each tick lowers it by one. The expiry happens on the tick that finds the count at 1 or below. A tick that arrives in a cycle with a bus write is dropped.
- R5: On the first expiry, status 1 bit 0 is set. An SMI pulse is raised if smi_tco_en_i is high, and an NMI pulse otherwise. The count then reloads from the timer value and the timer keeps running.
- R6: On the second consecutive expiry, status 2 bits 0 and 1 are set and the timeout count clears. If reboot is allowed, the block gives a single reboot pulse with no SMI or NMI, the timer stops and the count reads 0.
- R7: When strap_noreboot_i or cfg_noreboot_i is high at the second expiry, no reboot is requested. The block instead raises the interrupt, reloads and keeps running as in R5, and the status 2 bits are still set.
- R8: A write to the count/reload register clears the timeout count. If the run conditions hold, the count restarts from the timer value and the timer runs. Otherwise the written value is stored and the run state is unchanged.
- R9: The lock bit (control 1 bit 1) is sticky: once written to 1, it stays 1 until reset.
- R10: A data-in write stores the byte, sets status 1 bit 1 and raises an SMI pulse. A data-out write stores the byte and sets status 1 bit 2.
- R11: Writes to status 1 and status 2 store the written value masked to the implemented bits (0x0007 and 0x0003).
- R12: The smi_o, nmi_o and reboot_o outputs are one-cycle pulses, at most one of them high in any cycle, in the cycle after the event's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Byte address |
| wr_i | input | 1 | Write strobe |
| be_i | input | 2 | Byte enables |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from addr_i |
| tick_i | input | 1 | Prescaler tick enable |
| strap_noreboot_i | input | 1 | Hardware no-reboot strap |
| cfg_noreboot_i | input | 1 | No-reboot configuration bit |
| smi_tco_en_i | input | 1 | Routes watchdog interrupts to SMI when high |
| smi_o | output | 1 | SMI pulse |
| nmi_o | output | 1 | NMI pulse |
| reboot_o | output | 1 | Reboot request pulse |

## Verification
The timeout sequencing is tried with four kinds of input pattern, each separating a different pair of behaviours:
- Plain runs of ticks show whether the first and second expiries are told apart.
- Runs with the strap and the configuration bit raised one at a time show whether each of them suppresses the reboot on its own.
- A reload written between two expiries shows whether the timeout count is really cleared, since the next expiry must give an interrupt rather than a reboot.
- Timer values of 0 and 1, the halt bit, and ticks that coincide with bus writes test the run gate and the dropped-tick rule.

A fixed-seed random phase then mixes writes to every register, odd-address byte accesses and toggled strap, configuration and routing inputs with the tick stream.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned DW = 16;

  typedef enum logic [2:0] {
    REG_RLD   = 3'd0,
    REG_MBOX  = 3'd1,
    REG_STS1  = 3'd2,
    REG_STS2  = 3'd3,
    REG_CTL1  = 3'd4,
    REG_CTL2  = 3'd5,
    REG_TMR   = 3'd6,
    REG_SWGEN = 3'd7
  } wdog_reg_e;

  localparam logic [DW-1:0] STS1_MASK = 16'h0007;
  localparam logic [DW-1:0] STS2_MASK = 16'h0003;
  localparam logic [DW-1:0] CTL1_MASK = 16'h0003;
  localparam logic [DW-1:0] CTL2_RST  = 16'h0008;
  localparam logic [7:0]    SWGEN_RST = 8'h03;

  localparam int unsigned S1_TIMEOUT = 0;
  localparam int unsigned S1_SWSMI   = 1;
  localparam int unsigned S1_DOUT    = 2;
  localparam int unsigned S2_SECOND  = 0;
  localparam int unsigned S2_BOOT    = 1;
  localparam int unsigned C1_HALT    = 0;
  localparam int unsigned C1_LOCK    = 1;

  typedef struct packed {
    logic timeout;
    logic second;
  } wdog_ev_t;

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] wd,
                                               input logic [1:0]    be);
    return {be[1] ? wd[15:8] : old_v[15:8], be[0] ? wd[7:0] : old_v[7:0]};
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned TMR_RST = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:1] widx_i,
  input  logic [1:0]        be_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     rld_i,
  input  wdog_ev_t          ev_i,
  output logic [DW-1:0]     rword_o,
  output logic [CNT_W-1:0]  tmr_o,
  output logic              halt_o,
  output logic              halt_nxt_o,
  output logic              wr_any_o,
  output logic              wr_rld_o,
  output logic              wr_ctl1_o,
  output logic              din_wr_o
);

  localparam int unsigned IDX_W = ADDR_W - 1;

  logic            mapped;
  wdog_reg_e       sel;
  logic            wr_any;
  logic [7:0]      din_q, dout_q, swgen_q;
  logic [DW-1:0]   sts1_q, sts2_q, ctl1_q, ctl2_q;
  logic [CNT_W-1:0] tmr_q;
  logic [DW-1:0]   ctl1_m, tmr_m;
  logic [DW-1:0]   sts1_set, sts2_set;
  logic            dout_wr;

  if (IDX_W > 3) begin : g_hi_dec
    assign mapped = (widx_i[ADDR_W-1:4] == '0);
  end else begin : g_full_dec
    assign mapped = 1'b1;
  end

  assign sel    = wdog_reg_e'(widx_i[3:1]);
  assign wr_any = wr_i && (|be_i) && mapped;

  assign wr_rld_o  = wr_any && (sel == REG_RLD);
  assign wr_ctl1_o = wr_any && (sel == REG_CTL1);
  assign din_wr_o  = wr_any && (sel == REG_MBOX) && be_i[0];
  assign dout_wr   = wr_any && (sel == REG_MBOX) && be_i[1];
  assign wr_any_o  = wr_i && (|be_i);

  assign ctl1_m     = lane_merge(ctl1_q, wdata_i, be_i);
  assign tmr_m      = lane_merge({{(DW-CNT_W){1'b0}}, tmr_q}, wdata_i, be_i);
  assign halt_nxt_o = ctl1_m[C1_HALT];
  assign halt_o     = ctl1_q[C1_HALT];
  assign tmr_o      = tmr_q;

  always_comb begin
    sts1_set = '0;
    sts1_set[S1_TIMEOUT] = ev_i.timeout;
    sts1_set[S1_SWSMI]   = din_wr_o;
    sts1_set[S1_DOUT]    = dout_wr;
    sts2_set = '0;
    sts2_set[S2_SECOND]  = ev_i.second;
    sts2_set[S2_BOOT]    = ev_i.second;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      din_q   <= '0;
      dout_q  <= '0;
      sts1_q  <= '0;
      sts2_q  <= '0;
      ctl1_q  <= '0;
      ctl2_q  <= CTL2_RST;
      tmr_q   <= CNT_W'(TMR_RST);
      swgen_q <= SWGEN_RST;
    end else begin
      if (wr_any && sel == REG_STS1) sts1_q <= lane_merge(sts1_q, wdata_i, be_i) & STS1_MASK;
      else                           sts1_q <= sts1_q | sts1_set;
      if (wr_any && sel == REG_STS2) sts2_q <= lane_merge(sts2_q, wdata_i, be_i) & STS2_MASK;
      else                           sts2_q <= sts2_q | sts2_set;
      if (din_wr_o) din_q  <= wdata_i[7:0];
      if (dout_wr)  dout_q <= wdata_i[15:8];
      if (wr_ctl1_o) begin
        ctl1_q <= (ctl1_m & CTL1_MASK) | (ctl1_q & (DW'(1) << C1_LOCK));
      end
      if (wr_any && sel == REG_CTL2) ctl2_q <= lane_merge(ctl2_q, wdata_i, be_i);
      if (wr_any && sel == REG_TMR)  tmr_q  <= tmr_m[CNT_W-1:0];
      if (wr_any && sel == REG_SWGEN && be_i[0]) swgen_q <= wdata_i[7:0];
    end
  end

  always_comb begin
    rword_o = '0;
    if (mapped) begin
      unique case (sel)
        REG_RLD:   rword_o = rld_i;
        REG_MBOX:  rword_o = {dout_q, din_q};
        REG_STS1:  rword_o = sts1_q;
        REG_STS2:  rword_o = sts2_q;
        REG_CTL1:  rword_o = ctl1_q;
        REG_CTL2:  rword_o = ctl2_q;
        REG_TMR:   rword_o = {{(DW-CNT_W){1'b0}}, tmr_q};
        REG_SWGEN: rword_o = {8'h00, swgen_q};
        default:   rword_o = '0;
      endcase
    end
  end

  // R9: lock survives every write
  p_lock_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctl1_q[C1_LOCK]) |-> ctl1_q[C1_LOCK]);

  // R11: status never holds unimplemented bits
  p_sts_masked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts1_q & ~STS1_MASK) == '0) && ((sts2_q & ~STS2_MASK) == '0));

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             bus_wr_i,
  input  logic             wr_rld_i,
  input  logic             wr_ctl1_i,
  input  logic [1:0]       be_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             halt_i,
  input  logic             halt_nxt_i,
  input  logic [CNT_W-1:0] tmr_i,
  input  logic             noreboot_i,
  input  logic             smi_en_i,
  input  logic             din_wr_i,
  output logic [DW-1:0]    rld_o,
  output wdog_ev_t         ev_o,
  output logic             smi_o,
  output logic             nmi_o,
  output logic             reboot_o
);

  logic [DW-1:0] rld_q, tmr_ext;
  logic          run_q, to_q;
  logic          tmr_ok, can_run, can_run_ctl;
  logic          tick_eff, expire, second, do_reboot, intr;
  logic          smi_q, nmi_q, reboot_q;

  assign tmr_ext     = {{(DW-CNT_W){1'b0}}, tmr_i};
  assign tmr_ok      = tmr_i > CNT_W'(1);
  assign can_run     = !halt_i && tmr_ok;
  assign can_run_ctl = !halt_nxt_i && tmr_ok;

  // bus writes own the cycle; a coincident tick is dropped
  assign tick_eff  = tick_i && !bus_wr_i;
  assign expire    = run_q && tick_eff && (rld_q <= DW'(1));
  assign second    = expire && to_q;
  assign do_reboot = second && !noreboot_i;
  assign intr      = expire && !do_reboot;

  assign ev_o.timeout = expire;
  assign ev_o.second  = second;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_q    <= '0;
      run_q    <= 1'b0;
      to_q     <= 1'b0;
      smi_q    <= 1'b0;
      nmi_q    <= 1'b0;
      reboot_q <= 1'b0;
    end else begin
      smi_q    <= (intr && smi_en_i) || din_wr_i;
      nmi_q    <= intr && !smi_en_i;
      reboot_q <= do_reboot;
      if (wr_rld_i) begin
        to_q <= 1'b0;
        if (can_run) begin
          rld_q <= tmr_ext;
          run_q <= 1'b1;
        end else begin
          rld_q <= lane_merge(rld_q, wdata_i, be_i);
        end
      end else if (wr_ctl1_i) begin
        if (can_run_ctl) begin
          rld_q <= tmr_ext;
          run_q <= 1'b1;
        end else begin
          run_q <= 1'b0;
        end
      end else if (expire) begin
        if (do_reboot) begin
          rld_q <= '0;
          run_q <= 1'b0;
          to_q  <= 1'b0;
        end else begin
          rld_q <= tmr_ext;
          to_q  <= !to_q;
        end
      end else if (run_q && tick_eff) begin
        rld_q <= rld_q - DW'(1);
      end
    end
  end

  assign rld_o    = rld_q;
  assign smi_o    = smi_q;
  assign nmi_o    = nmi_q;
  assign reboot_o = reboot_q;

  p_pulse_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({smi_o, nmi_o, reboot_o}));

  p_reboot_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_o |-> !$past(noreboot_i));

  p_reboot_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_o |-> (!run_q && rld_q == '0 && !to_q));

  p_start_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> (!halt_i && tmr_i > CNT_W'(1)));

  p_count_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_q) && $past(tick_i) && !$past(bus_wr_i) && $past(rld_q) > DW'(1))
      |-> rld_q == $past(rld_q) - DW'(1));

endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned TMR_RST = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [1:0]        be_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              tick_i,
  input  logic              strap_noreboot_i,
  input  logic              cfg_noreboot_i,
  input  logic              smi_tco_en_i,
  output logic              smi_o,
  output logic              nmi_o,
  output logic              reboot_o
);

  logic [1:0]       be_w;
  logic [DW-1:0]    wd_w, rword, rld;
  logic [CNT_W-1:0] tmr;
  logic             halt, halt_nxt, wr_any, wr_rld, wr_ctl1, din_wr;
  logic             noreboot;
  wdog_ev_t         ev;

  // odd address: byte access to the upper lane
  assign be_w    = addr_i[0] ? {be_i[0], 1'b0} : be_i;
  assign wd_w    = addr_i[0] ? {wdata_i[7:0], 8'h00} : wdata_i;
  assign rdata_o = addr_i[0] ? {8'h00, rword[15:8]} : rword;

  // strap high forces no-reboot regardless of the config bit
  assign noreboot = strap_noreboot_i || cfg_noreboot_i;

  wdog_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .TMR_RST(TMR_RST)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .widx_i    (addr_i[ADDR_W-1:1]),
    .be_i      (be_w),
    .wdata_i   (wd_w),
    .rld_i     (rld),
    .ev_i      (ev),
    .rword_o   (rword),
    .tmr_o     (tmr),
    .halt_o    (halt),
    .halt_nxt_o(halt_nxt),
    .wr_any_o  (wr_any),
    .wr_rld_o  (wr_rld),
    .wr_ctl1_o (wr_ctl1),
    .din_wr_o  (din_wr)
  );

  wdog_core #(
    .CNT_W(CNT_W)
  ) i_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .bus_wr_i  (wr_any),
    .wr_rld_i  (wr_rld),
    .wr_ctl1_i (wr_ctl1),
    .be_i      (be_w),
    .wdata_i   (wd_w),
    .halt_i    (halt),
    .halt_nxt_i(halt_nxt),
    .tmr_i     (tmr),
    .noreboot_i(noreboot),
    .smi_en_i  (smi_tco_en_i),
    .din_wr_i  (din_wr),
    .rld_o     (rld),
    .ev_o      (ev),
    .smi_o     (smi_o),
    .nmi_o     (nmi_o),
    .reboot_o  (reboot_o)
  );

endmodule

// File: tb/test_wdog_twostage.sv
module test_wdog_twostage;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic [1:0]  be_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        tick_i = 1'b0;
  logic        strap_noreboot_i = 1'b0;
  logic        cfg_noreboot_i = 1'b0;
  logic        smi_tco_en_i = 1'b0;
  logic        smi_o, nmi_o, reboot_o;

  int checks = 0;
  int errors = 0;

  // expected state built from the requirements
  logic [15:0] m_rld, m_sts1, m_sts2, m_ctl1, m_ctl2, m_tmr;
  logic [7:0]  m_din, m_dout, m_swgen;
  logic        m_run, m_to;

  wdog_twostage i_wdog_twostage (.*);

  always #5 clk_i = ~clk_i;

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mword(input logic [3:0] idx);
    case (idx)
      4'd0: return m_rld;
      4'd1: return {m_dout, m_din};
      4'd2: return m_sts1;
      4'd3: return m_sts2;
      4'd4: return m_ctl1;
      4'd5: return m_ctl2;
      4'd6: return m_tmr;
      4'd7: return {8'h00, m_swgen};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] mg(input logic [15:0] o, input logic [15:0] w, input logic [1:0] b);
    return {b[1] ? w[15:8] : o[15:8], b[0] ? w[7:0] : o[7:0]};
  endfunction

  // one bus cycle; called and returns at a falling edge
  task automatic cyc(input logic wr, input logic [4:0] a, input logic [1:0] be,
                     input logic [15:0] wd, input logic tk, input string tag);
    logic [1:0]  bw;
    logic [15:0] ww, rw;
    logic [3:0]  idx;
    logic        e_smi, e_nmi, e_rb, intr;
    addr_i = a; wr_i = wr; be_i = be; wdata_i = wd; tick_i = tk;
    bw  = a[0] ? {be[0], 1'b0} : be;
    ww  = a[0] ? {wd[7:0], 8'h00} : wd;
    idx = a[4:1];
    #1;
    if (!wr) begin
      rw = mword(idx);
      chk(tag, rdata_o, a[0] ? {8'h00, rw[15:8]} : rw);
    end
    e_smi = 0; e_nmi = 0; e_rb = 0; intr = 0;
    if (wr && |bw) begin
      case (idx)
        4'd0: begin
          m_to = 0;
          if (!m_ctl1[0] && m_tmr > 1) begin m_rld = m_tmr; m_run = 1; end
          else m_rld = mg(m_rld, ww, bw);
        end
        4'd1: begin
          if (bw[0]) begin m_din = ww[7:0]; m_sts1[1] = 1; e_smi = 1; end
          if (bw[1]) begin m_dout = ww[15:8]; m_sts1[2] = 1; end
        end
        4'd2: m_sts1 = mg(m_sts1, ww, bw) & 16'h0007;
        4'd3: m_sts2 = mg(m_sts2, ww, bw) & 16'h0003;
        4'd4: begin
          m_ctl1 = (mg(m_ctl1, ww, bw) & 16'h0003) | (m_ctl1 & 16'h0002);
          m_run = !m_ctl1[0] && m_tmr > 1;
          if (m_run) m_rld = m_tmr;
        end
        4'd5: m_ctl2 = mg(m_ctl2, ww, bw);
        4'd6: m_tmr = mg(m_tmr, ww, bw) & 16'h03FF;
        4'd7: if (bw[0]) m_swgen = ww[7:0];
        default: ;
      endcase
    end else if (tk && m_run) begin
      if (m_rld > 1) m_rld = m_rld - 1;
      else begin
        m_sts1[0] = 1;
        if (m_to) begin
          m_sts2 = m_sts2 | 16'h0003;
          m_to = 0;
          if (!(strap_noreboot_i || cfg_noreboot_i)) begin
            e_rb = 1; m_run = 0; m_rld = 0;
          end else intr = 1;
        end else begin
          m_to = 1; intr = 1;
        end
        if (intr) begin
          if (smi_tco_en_i) e_smi = 1; else e_nmi = 1;
          m_rld = m_tmr;
        end
      end
    end
    @(posedge clk_i);
    #1;
    chk({tag, " pulses"}, {13'd0, smi_o, nmi_o, reboot_o}, {13'd0, e_smi, e_nmi, e_rb});
    @(negedge clk_i);
  endtask

  task automatic wr16(input logic [4:0] a, input logic [15:0] d, input string tag);
    cyc(1, a, 2'b11, d, 0, tag);
  endtask
  task automatic rd(input logic [4:0] a, input string tag);
    cyc(0, a, 2'b00, 16'h0, 0, tag);
  endtask
  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 5'h00, 2'b00, 16'h0, 1, tag);
  endtask

  initial begin
    m_rld = 0; m_sts1 = 0; m_sts2 = 0; m_ctl1 = 0; m_ctl2 = 16'h0008; m_tmr = 4;
    m_din = 0; m_dout = 0; m_swgen = 8'h03; m_run = 0; m_to = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int a = 0; a <= 16; a += 2) rd(5'(a), "R1 reset");

    cyc(1, 5'h0A, 2'b10, 16'hAB55, 0, "R2 lane");
    rd(5'h0A, "R2 lane");
    cyc(1, 5'h0E, 2'b10, 16'hFF00, 0, "R2 swgen hi");
    rd(5'h0E, "R2 swgen");
    rd(5'h12, "R2 unmapped");
    cyc(1, 5'h0B, 2'b01, 16'h00C4, 0, "R2 odd write");
    rd(5'h0B, "R2 odd read");
    rd(5'h0A, "R2 odd word");

    ticks(5, "R3 idle");
    wr16(5'h0C, 16'h0001, "R3 tmr1");
    wr16(5'h00, 16'h0033, "R8 store");
    wr16(5'h08, 16'h0000, "R3 tmr1 ctl");
    ticks(3, "R3 no run");
    rd(5'h00, "R3 held");
    wr16(5'h0C, 16'h0000, "R3 tmr0");
    wr16(5'h08, 16'h0000, "R3 tmr0 ctl");
    ticks(3, "R3 no run");
    rd(5'h00, "R3 held");
    wr16(5'h0C, 16'h0005, "R3 tmr5");
    wr16(5'h08, 16'h0001, "R3 halt");
    ticks(3, "R3 halted");
    rd(5'h00, "R3 halted");
    wr16(5'h08, 16'h0000, "R3 start");
    rd(5'h00, "R3 start");

    ticks(2, "R4 count");
    rd(5'h00, "R4 remaining");
    cyc(1, 5'h0A, 2'b11, 16'h1234, 1, "R4 drop");
    rd(5'h00, "R4 dropped");

    smi_tco_en_i = 1'b1;
    ticks(3, "R5 first");
    rd(5'h04, "R5 sts1");
    rd(5'h00, "R5 reload");
    ticks(5, "R6 second");
    rd(5'h06, "R6 sts2");
    rd(5'h00, "R6 stopped");
    ticks(4, "R6 idle");

    wr16(5'h04, 16'hFFFF, "R11 sts1");
    rd(5'h04, "R11 sts1");
    wr16(5'h06, 16'hFFFC, "R11 sts2");
    rd(5'h06, "R11 sts2");

    smi_tco_en_i = 1'b0;
    strap_noreboot_i = 1'b1;
    wr16(5'h08, 16'h0000, "R7 strap");
    ticks(12, "R7 strap");
    rd(5'h06, "R7 sts2");
    strap_noreboot_i = 1'b0;
    cfg_noreboot_i = 1'b1;
    wr16(5'h00, 16'h0000, "R7 cfg");
    ticks(12, "R7 cfg");
    cfg_noreboot_i = 1'b0;

    wr16(5'h00, 16'h0000, "R8 restart");
    ticks(5, "R8 first");
    wr16(5'h00, 16'h0000, "R8 clear");
    rd(5'h00, "R8 reloaded");
    ticks(5, "R8 again first");
    ticks(5, "R8 then reboot");

    wr16(5'h08, 16'h0002, "R9 lock");
    wr16(5'h08, 16'h0000, "R9 try clear");
    rd(5'h08, "R9 lock held");
    wr16(5'h08, 16'h0001, "R9 halt");
    rd(5'h08, "R9 lock halt");

    cyc(1, 5'h02, 2'b01, 16'h995A, 0, "R10 din");
    rd(5'h02, "R10 mbox");
    rd(5'h04, "R10 sts1");
    cyc(1, 5'h03, 2'b01, 16'h00C3, 0, "R10 dout");
    rd(5'h02, "R10 mbox");
    rd(5'h04, "R10 sts1");

    wr16(5'h08, 16'h0000, "R12 run");
    for (int n = 0; n < 4000; n++) begin
      logic [4:0]  a;
      logic [15:0] d;
      logic [1:0]  b;
      if ($urandom_range(0, 63) == 0) strap_noreboot_i = ~strap_noreboot_i;
      if ($urandom_range(0, 63) == 0) cfg_noreboot_i = ~cfg_noreboot_i;
      if ($urandom_range(0, 31) == 0) smi_tco_en_i = ~smi_tco_en_i;
      a = 5'($urandom_range(0, 17));
      d = 16'($urandom);
      b = 2'($urandom_range(0, 3));
      if (a[4:1] == 4'd6) d = 16'($urandom_range(0, 7));
      if (a[4:1] == 4'd4 && $urandom_range(0, 3) != 0) d[0] = 1'b0;
      if ($urandom_range(0, 9) == 0) cyc(1, a, b, d, 1'($urandom), "R12 mix");
      else cyc(0, a, 2'b00, 16'h0, 1'($urandom), "R12 mix");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule